// File: doc/BRIEF.md
# Unsolicited Event Token Injector

This block lets a structure-memory unit act as a token source. It watches a set of device event lines and turns each rising edge into a pre-formed two-flit network token, provided no deferred read is waiting on the cell that belongs to that source. When a read is waiting, the injector stays silent and the ordinary deferred-read path delivers the event.

Each event source owns one template slot. A slot holds a head flit (routing), a tail flit (data or source word) and an enable bit. Slots are written through a small configuration port that the unit's address decoder drives for writes to its reserved range, usually during bootstrap. Edges that cannot be sent at once are remembered per source. They are served later, lowest source index first.

The injector shares the unit's outgoing bus with normal response traffic. Responses always win a tie, so replies to requests already made are never delayed by spontaneous traffic. Once the head flit of a template is on the bus, the tail flit follows on the very next cycle, and the response path is stalled for that one cycle.

Top module: `evt_dispatch`

## Requirements
- R1: While reset is held and just after it, bus_valid_o is low, bus_flit_o is zero, rsp_ready_o is high, no event is remembered and all slots are disabled.
- R2: Only a low-to-high change of an event line between two consecutive clock edges counts as an event. A line held high gives exactly one token, and a falling edge gives none.
- R3: An edge on source i in a cycle where defer_pend_i[i] is high is dropped and produces no token.
- R4: A disabled slot drops its edges. Clearing the enable of a slot that has a remembered event discards that event, provided the slot has not already started sending.
- R5: A token is the slot's head flit followed by its tail flit, with bus_valid_o high on two consecutive cycles. For an edge in cycle t on a free bus, the head flit appears in cycle t+1.
- R6: When the injector is not in a tail cycle and rsp_valid_i is high, the bus carries rsp_flit_i and rsp_ready_o is high, and the injector waits. bus_flit_o is zero whenever bus_valid_o is low.
- R7: In the tail cycle, rsp_ready_o is low and the bus carries the tail flit, whatever rsp_valid_i is. There is never more than one stall cycle in a row.
- R8: Remembered events wait while the bus is busy. When the bus frees, they are sent one token at a time, lowest source index first.
- R9: Both flits of a token come from the slot contents at the cycle the head flit is sent. A configuration write in that cycle affects only later tokens.
- R10: A configuration address is {source index, select[1:0]}. Select 0 writes the head flit, 1 writes the tail flit, 2 writes the enable from cfg_wdata_i[0], and 3 has no effect. A write becomes visible on the next cycle.
- R11: An edge on a source in the same cycle that the source's earlier event starts sending is kept, and it gives a second token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | N_SRC | Device event lines, one per source |
| defer_pend_i | input | N_SRC | Cell controller: a deferred read is pending on the source's cell |
| cfg_we_i | input | 1 | Slot write strobe |
| cfg_addr_i | input | IDX_W+2 | Slot write address {source, select} |
| cfg_wdata_i | input | FLIT_W | Slot write data |
| rsp_valid_i | input | 1 | Normal response flit offered |
| rsp_flit_i | input | FLIT_W | Normal response flit |
| rsp_ready_o | output | 1 | Response flit accepted onto the bus this cycle |
| bus_valid_o | output | 1 | Bus carries a flit |
| bus_flit_o | output | FLIT_W | Bus flit |

## Verification
The properties assume that all inputs are synchronous to clk and that a response flit counts as sent only in a cycle where rsp_ready_o is high. They place no limit on how often rsp_valid_i is high, and none on how event lines and the pending-read flags change. The stimulus changes every input just after a rising edge and holds it for the whole cycle. It covers long stretches of busy response traffic, responses that arrive during tail cycles, and slot writes that coincide with the start of a token, so that the ordering and capture rules are exercised at their edges.

// File: rtl/evt_dispatch_pkg.sv
package evt_dispatch_pkg;

    // Emission phase: idle or driving the tail flit of a template.
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_TAIL = 1'b1
    } phase_e;

    // Low two bits of a slot configuration address.
    localparam logic [1:0] SEL_HEAD   = 2'd0;
    localparam logic [1:0] SEL_TAIL   = 2'd1;
    localparam logic [1:0] SEL_ENABLE = 2'd2;

endpackage

// File: rtl/evt_edge_latch.sv
module evt_edge_latch #(
    parameter int N_SRC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] evt_i,
    input  logic [N_SRC-1:0] en_i,
    input  logic [N_SRC-1:0] defer_i,
    input  logic [N_SRC-1:0] serve_i,
    output logic [N_SRC-1:0] pend_o
);

    typedef struct packed {
        logic [N_SRC-1:0] evt_prev;
        logic [N_SRC-1:0] pend;
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic [N_SRC-1:0] rise;

    always_comb begin
        st_d          = st_q;
        rise          = evt_i & ~st_q.evt_prev;
        st_d.evt_prev = evt_i;
        for (int i = 0; i < N_SRC; i++) begin
            if (!en_i[i]) begin
                // disabled slot: nothing is remembered
                st_d.pend[i] = 1'b0;
            end else begin
                // a fresh edge wins over the clear of the one being served
                st_d.pend[i] = (st_q.pend[i] & ~serve_i[i]) | (rise[i] & ~defer_i[i]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;

endmodule

// File: rtl/evt_prio_pick.sv
module evt_prio_pick #(
    parameter int N_SRC = 4,
    parameter int IDX_W = 2
) (
    input  logic [N_SRC-1:0] req_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [N_SRC-1:0] grant_o
);

    // blocked[i]: some lower-index request is active
    logic [N_SRC:0] blocked;

    assign blocked[0] = 1'b0;

    genvar g;
    generate
        for (g = 0; g < N_SRC; g++) begin : g_chain
            assign blocked[g+1] = blocked[g] | req_i[g];
            assign grant_o[g]   = req_i[g] & ~blocked[g];
        end
    endgenerate

    assign any_o = blocked[N_SRC];

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (grant_o[i]) begin
                idx_o = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/evt_tmpl_table.sv
module evt_tmpl_table
    import evt_dispatch_pkg::*;
#(
    parameter int N_SRC  = 4,
    parameter int FLIT_W = 16,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [IDX_W+1:0]  wr_addr_i,
    input  logic [FLIT_W-1:0] wr_data_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [FLIT_W-1:0] rd_head_o,
    output logic [FLIT_W-1:0] rd_tail_o,
    output logic [N_SRC-1:0]  en_o
);

    typedef struct packed {
        logic [N_SRC-1:0][FLIT_W-1:0] head;
        logic [N_SRC-1:0][FLIT_W-1:0] tail;
        logic [N_SRC-1:0]             en;
    } tbl_st_t;

    tbl_st_t tb_d, tb_q;

    logic [IDX_W-1:0] wr_slot;
    logic [1:0]       wr_sel;

    assign wr_slot = wr_addr_i[IDX_W+1:2];
    assign wr_sel  = wr_addr_i[1:0];

    always_comb begin
        tb_d = tb_q;
        if (wr_en_i) begin
            for (int i = 0; i < N_SRC; i++) begin
                if (wr_slot == IDX_W'(i)) begin
                    case (wr_sel)
                        SEL_HEAD:   tb_d.head[i] = wr_data_i;
                        SEL_TAIL:   tb_d.tail[i] = wr_data_i;
                        SEL_ENABLE: tb_d.en[i]   = wr_data_i[0];
                        default:    ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tb_q <= '0;
        end else begin
            tb_q <= tb_d;
        end
    end

    always_comb begin
        rd_head_o = '0;
        rd_tail_o = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (rd_idx_i == IDX_W'(i)) begin
                rd_head_o = tb_q.head[i];
                rd_tail_o = tb_q.tail[i];
            end
        end
    end

    assign en_o = tb_q.en;

endmodule

// File: rtl/evt_dispatch.sv
module evt_dispatch
    import evt_dispatch_pkg::*;
#(
    parameter int N_SRC  = 4,
    parameter int FLIT_W = 16,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1,
    localparam int CFG_AW = IDX_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  evt_i,
    input  logic [N_SRC-1:0]  defer_pend_i,
    input  logic              cfg_we_i,
    input  logic [CFG_AW-1:0] cfg_addr_i,
    input  logic [FLIT_W-1:0] cfg_wdata_i,
    input  logic              rsp_valid_i,
    input  logic [FLIT_W-1:0] rsp_flit_i,
    output logic              rsp_ready_o,
    output logic              bus_valid_o,
    output logic [FLIT_W-1:0] bus_flit_o
);

    typedef struct packed {
        phase_e            phase;
        logic [FLIT_W-1:0] tail;
    } emit_st_t;

    emit_st_t st_d, st_q;

    logic [N_SRC-1:0]  slot_en;
    logic [N_SRC-1:0]  pend;
    logic [N_SRC-1:0]  eff_req;
    logic [N_SRC-1:0]  pick_grant;
    logic [N_SRC-1:0]  serve;
    logic              pick_any;
    logic [IDX_W-1:0]  pick_idx;
    logic [FLIT_W-1:0] head_rd;
    logic [FLIT_W-1:0] tail_rd;

    evt_tmpl_table #(
        .N_SRC (N_SRC),
        .FLIT_W(FLIT_W),
        .IDX_W (IDX_W)
    ) tbl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (cfg_we_i),
        .wr_addr_i(cfg_addr_i),
        .wr_data_i(cfg_wdata_i),
        .rd_idx_i (pick_idx),
        .rd_head_o(head_rd),
        .rd_tail_o(tail_rd),
        .en_o     (slot_en)
    );

    evt_edge_latch #(
        .N_SRC(N_SRC)
    ) edge_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt_i),
        .en_i   (slot_en),
        .defer_i(defer_pend_i),
        .serve_i(serve),
        .pend_o (pend)
    );

    assign eff_req = pend & slot_en;

    evt_prio_pick #(
        .N_SRC(N_SRC),
        .IDX_W(IDX_W)
    ) pick_i (
        .req_i  (eff_req),
        .any_o  (pick_any),
        .idx_o  (pick_idx),
        .grant_o(pick_grant)
    );

    always_comb begin
        st_d        = st_q;
        serve       = '0;
        rsp_ready_o = 1'b1;
        bus_valid_o = 1'b0;
        bus_flit_o  = '0;
        if (st_q.phase == PH_TAIL) begin
            // second flit goes out unconditionally, responses stall
            bus_valid_o = 1'b1;
            bus_flit_o  = st_q.tail;
            rsp_ready_o = 1'b0;
            st_d.phase  = PH_IDLE;
        end else if (rsp_valid_i) begin
            // normal reply traffic has priority
            bus_valid_o = 1'b1;
            bus_flit_o  = rsp_flit_i;
        end else if (pick_any) begin
            bus_valid_o = 1'b1;
            bus_flit_o  = head_rd;
            st_d.phase  = PH_TAIL;
            st_d.tail   = tail_rd;
            serve       = pick_grant;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, tail: '0};
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/evt_dispatch_chk.sv
module evt_dispatch_chk #(
    parameter int N_SRC  = 4,
    parameter int FLIT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rsp_valid_i,
    input logic [FLIT_W-1:0] rsp_flit_i,
    input logic              rsp_ready_o,
    input logic              bus_valid_o,
    input logic [FLIT_W-1:0] bus_flit_o,
    input logic [N_SRC-1:0]  eff_req
);

    // R6: an accepted reply occupies the bus unchanged
    a_r6_reply_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_i && rsp_ready_o) |-> (bus_valid_o && bus_flit_o == rsp_flit_i));

    // R6: an empty bus carries zero
    a_r6_quiet_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid_o |-> (bus_flit_o == '0));

    // R5, R7: a spontaneous head flit is followed by the tail with replies held
    a_r7_tail_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid_o && rsp_ready_o && !rsp_valid_i) |=> (bus_valid_o && !rsp_ready_o));

    // R7: replies are never stalled two cycles in a row
    a_r7_single_stall: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_ready_o |=> rsp_ready_o);

    // R8: remembered work is never left waiting on a free bus
    a_r8_no_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
        ((|eff_req) && rsp_ready_o) |-> bus_valid_o);

endmodule

bind evt_dispatch evt_dispatch_chk #(
    .N_SRC (N_SRC),
    .FLIT_W(FLIT_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rsp_valid_i(rsp_valid_i),
    .rsp_flit_i (rsp_flit_i),
    .rsp_ready_o(rsp_ready_o),
    .bus_valid_o(bus_valid_o),
    .bus_flit_o (bus_flit_o),
    .eff_req    (eff_req)
);

// File: tb/evt_dispatch_tb_top.sv
`timescale 1ns/1ps
module evt_dispatch_tb_top;

    localparam int N = 4;
    localparam int W = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  evt = '0;
    logic [N-1:0]  defer = '0;
    logic          cfg_we = 1'b0;
    logic [3:0]    cfg_addr = '0;
    logic [W-1:0]  cfg_wdata = '0;
    logic          rsp_valid = 1'b0;
    logic [W-1:0]  rsp_flit = '0;
    logic          rsp_ready;
    logic          bus_valid;
    logic [W-1:0]  bus_flit;

    always #2.5 clk = ~clk;

    evt_dispatch #(.N_SRC(N), .FLIT_W(W)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       (evt),
        .defer_pend_i(defer),
        .cfg_we_i    (cfg_we),
        .cfg_addr_i  (cfg_addr),
        .cfg_wdata_i (cfg_wdata),
        .rsp_valid_i (rsp_valid),
        .rsp_flit_i  (rsp_flit),
        .rsp_ready_o (rsp_ready),
        .bus_valid_o (bus_valid),
        .bus_flit_o  (bus_flit)
    );

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // behavioural reference state
    bit       m_pend[N];
    bit       m_en[N];
    bit       m_prev[N];
    bit [W-1:0] m_head[N];
    bit [W-1:0] m_tail[N];
    bit       m_in_tail;
    bit [W-1:0] m_tail_lat;
    int       tokens_seen;

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_pend[i] = 0; m_en[i] = 0; m_prev[i] = 0;
            m_head[i] = '0; m_tail[i] = '0;
        end
        m_in_tail  = 0;
        m_tail_lat = '0;
    endtask

    task automatic chk(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One clock cycle: inputs were set just after the previous rising edge.
    task automatic step(input string tag);
        int      sel;
        bit      start;
        bit      ev;
        bit      er;
        bit [W-1:0] ef;
        @(negedge clk);
        #1;
        sel = -1;
        for (int i = 0; i < N; i++)
            if (sel < 0 && m_pend[i] && m_en[i]) sel = i;
        start = !m_in_tail && !rsp_valid && (sel >= 0);
        if (!rst_n) begin
            ev = rsp_valid; ef = rsp_valid ? rsp_flit : '0; er = 1;
            if (!m_in_tail && !rsp_valid) begin ev = 0; ef = '0; end
            ev = 0; ef = '0; er = 1;
        end else if (m_in_tail) begin
            ev = 1; ef = m_tail_lat; er = 0;
        end else if (rsp_valid) begin
            ev = 1; ef = rsp_flit; er = 1;
        end else if (start) begin
            ev = 1; ef = m_head[sel]; er = 1;
        end else begin
            ev = 0; ef = '0; er = 1;
        end
        if (!rst_n) begin
            // during reset only the reply-free outputs are defined by R1
            chk("R1", "bus_valid", int'(bus_valid), 0);
            chk("R1", "rsp_ready", int'(rsp_ready), 1);
            model_reset();
        end else begin
            chk(tag, "bus_valid", int'(bus_valid), int'(ev));
            chk(tag, "bus_flit", int'(bus_flit), int'(ef));
            chk(er ? tag : "R7", "rsp_ready", int'(rsp_ready), int'(er));
            if (start) tokens_seen++;
            // next state
            for (int i = 0; i < N; i++) begin
                bit rise;
                rise = evt[i] && !m_prev[i];
                if (!m_en[i]) m_pend[i] = 0;
                else m_pend[i] = (m_pend[i] && !(start && sel == i)) || (rise && !defer[i]);
                m_prev[i] = evt[i];
            end
            if (m_in_tail) m_in_tail = 0;
            else if (start) begin
                m_in_tail  = 1;
                m_tail_lat = m_tail[sel];
            end
            if (cfg_we && int'(cfg_addr[3:2]) < N) begin
                case (cfg_addr[1:0])
                    2'd0: m_head[cfg_addr[3:2]] = cfg_wdata;
                    2'd1: m_tail[cfg_addr[3:2]] = cfg_wdata;
                    2'd2: m_en[cfg_addr[3:2]]   = cfg_wdata[0];
                    default: ;
                endcase
            end
        end
        @(posedge clk);
        #1;
    endtask

    task automatic steps(input string tag, input int n);
        for (int k = 0; k < n; k++) step(tag);
    endtask

    task automatic cfg_wr(input int src, input int sel, input bit [W-1:0] data, input string tag);
        cfg_we    = 1'b1;
        cfg_addr  = {2'(src), 2'(sel)};
        cfg_wdata = data;
        step(tag);
        cfg_we    = 1'b0;
    endtask

    // watchdog
    initial begin
        #(200000 * 5);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int cnt_before;
        bit [15:0] lfsr;
        model_reset();
        tokens_seen = 0;
        #1;
        // R1: reset
        steps("R1", 3);
        rst_n = 1'b1;
        steps("R1", 2);

        // R10: program slots; slot 3 left disabled
        for (int i = 0; i < N; i++) begin
            cfg_wr(i, 0, 16'hA100 + 16'(i * 16'h0011), "R10");
            cfg_wr(i, 1, 16'hB200 + 16'(i * 16'h0022), "R10");
            if (i < 3) cfg_wr(i, 2, 16'h0001, "R10");
        end
        cfg_wr(0, 3, 16'hFFFF, "R10");   // select 3: no effect

        // R2, R5: held-high line gives one token, falling edge none
        cnt_before = tokens_seen;
        evt[1] = 1'b1;
        steps("R2", 5);
        evt[1] = 1'b0;
        steps("R2", 3);
        chk("R2", "token count", tokens_seen - cnt_before, 1);

        // R3: edge with pending deferred read is dropped
        cnt_before = tokens_seen;
        defer[0] = 1'b1; evt[0] = 1'b1;
        step("R3");
        defer[0] = 1'b0;
        steps("R3", 3);
        evt[0] = 1'b0;
        step("R3");
        chk("R3", "token count", tokens_seen - cnt_before, 0);

        // R4: disabled slot drops its edge
        cnt_before = tokens_seen;
        evt[3] = 1'b1;
        steps("R4", 3);
        evt[3] = 1'b0;
        step("R4");
        chk("R4", "token count", tokens_seen - cnt_before, 0);
        cfg_wr(3, 2, 16'h0001, "R10");

        // R8, R6: edges remembered behind reply traffic, lowest index first
        cnt_before = tokens_seen;
        rsp_valid = 1'b1; rsp_flit = 16'h5A5A;
        evt[2] = 1'b1; evt[3] = 1'b1;
        steps("R6", 3);
        rsp_valid = 1'b0;
        steps("R8", 6);
        evt = '0;
        step("R8");
        chk("R8", "token count", tokens_seen - cnt_before, 2);

        // R4: clearing enable discards a remembered event
        cnt_before = tokens_seen;
        rsp_valid = 1'b1; rsp_flit = 16'h0F0F;
        evt[1] = 1'b1;
        step("R4");
        cfg_wr(1, 2, 16'h0000, "R4");
        steps("R4", 2);
        rsp_valid = 1'b0;
        steps("R4", 4);
        evt = '0;
        step("R4");
        chk("R4", "token count", tokens_seen - cnt_before, 0);
        cfg_wr(1, 2, 16'h0001, "R10");

        // R9: write to tail flit in the head cycle affects only later tokens
        evt[0] = 1'b1;
        step("R9");
        cfg_we = 1'b1; cfg_addr = {2'd0, 2'd1}; cfg_wdata = 16'hC0DE;
        step("R9");
        cfg_we = 1'b0;
        steps("R9", 3);
        evt[0] = 1'b0;
        step("R9");
        evt[0] = 1'b1;
        steps("R9", 4);
        evt[0] = 1'b0;
        step("R9");

        // R7: reply offered during the tail cycle is stalled one cycle
        evt[2] = 1'b1;
        step("R7");
        step("R7");
        rsp_valid = 1'b1; rsp_flit = 16'h7777;
        steps("R7", 3);
        rsp_valid = 1'b0;
        evt[2] = 1'b0;
        steps("R7", 2);

        // R11: fresh edge in the cycle its earlier event starts sending
        cnt_before = tokens_seen;
        rsp_valid = 1'b1; rsp_flit = 16'h1111;
        evt[1] = 1'b1;
        step("R11");
        evt[1] = 1'b0;
        step("R11");
        rsp_valid = 1'b0;
        evt[1] = 1'b1;
        step("R11");
        steps("R11", 5);
        evt[1] = 1'b0;
        step("R11");
        chk("R11", "token count", tokens_seen - cnt_before, 2);

        // mixed traffic
        lfsr = 16'hACE1;
        for (int k = 0; k < 600; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            evt       = lfsr[3:0];
            defer     = lfsr[7:4] & lfsr[11:8];
            rsp_valid = lfsr[9] & lfsr[14];
            rsp_flit  = lfsr ^ 16'h3C3C;
            cfg_we    = (lfsr[15:12] == 4'hF);
            cfg_addr  = {lfsr[1:0], lfsr[6] ? 2'd2 : 2'd1};
            cfg_wdata = {lfsr[7:0], lfsr[15:8]} | 16'h0001;
            step("R8");
        end
        cfg_we = 1'b0; rsp_valid = 1'b0; evt = '0; defer = '0;
        steps("R8", 12);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule